// File: doc/BRIEF.md
# Serial PCM Framing Port

This block is the serial front end of a 32-slot, 8-bit PCM highway. It runs on a master clock at twice the bit rate and takes an active-low 8 kHz frame pulse. From these it recovers the frame position and splits each frame into slots and bit cells. Serial input bytes are assembled and handed to downstream logic with a one-cycle strobe and the slot number. Parallel bytes from downstream are shifted back out, MSB first, on a data line with a separate output enable. The enable is raised only in slots the downstream logic selects.

Every byte passes through a selectable inversion format, in both directions. An extra-bit mode supports 193-bit frames. In that mode the first bit cell after the pulse is a framing bit, and an exported copy of the clock is held low for the first two clock cycles of each frame. Two tone control inputs are captured once per frame, so all slots of a frame see the same tone state. After reset the output stays disabled for two whole frames.

Top module: `pcm_serial_port`

## Requirements
- R1: Nothing runs until the first frame pulse. The clock edge that first samples `fp_n` low after it was high restarts the frame, and the next clock cycle is the first half of cell 0. Every later pulse realigns the frame the same way. `rx_slot` reports the slot of the byte being delivered.
- R2: Each bit cell spans two clock cycles. `din` is sampled at the edge that ends the first cycle of the cell, and bytes arrive MSB first. `rx_stb` is high for exactly one cycle: the second cycle of the cell that holds bit 7 (the LSB) of a slot.
- R3: `tx_byte` and `tx_sel` are sampled at the edge that starts bit 0 of a slot. `dout` changes only at cell starts and sends the byte MSB first.
- R4: `dout_oe` is high for all cells of a slot whose sampled `tx_sel` was 1, and low in every other cell.
- R5: `fmt` selects an XOR mask that is applied to received bytes before delivery and to sent bytes before serialisation. Code 0 uses mask 0x00. Code 1 uses 0x55 (bits 0, 2, 4, 6). Code 2 uses 0x2A (bits 1, 3, 5). Code 3 uses 0x7F (bits 0 to 6). Bit 7 is never inverted.
- R6: When `xbit` is 1, cell 0 of each frame is a framing bit. It yields no received data and `dout_oe` stays low during it. Slot 0 starts at cell 1.
- R7: `clk_out` equals `clk`. The exception is `xbit` = 1, where `clk_out` is held low during clock cycles 0 and 1 of every frame.
- R8: `tone_dur` and `tone_frq` take the values of `td` and `tf` at the frame-restart edge and hold them for the whole frame.
- R9: `dout_oe` stays low until the third frame pulse after reset.
- R10: During and just after reset, `rx_stb` and `dout_oe` are low and `clk_out` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse |
| din | input | 1 | Serial PCM input |
| xbit | input | 1 | Extra framing bit mode |
| fmt | input | 2 | Byte inversion format code |
| td | input | 1 | Tone duration control |
| tf | input | 1 | Tone frequency control |
| tx_byte | input | 8 | Byte to send in the slot being started |
| tx_sel | input | 1 | Drive the line in the slot being started |
| dout | output | 1 | Serial PCM output data |
| dout_oe | output | 1 | Output enable for `dout` |
| clk_out | output | 1 | Exported clock |
| rx_stb | output | 1 | Received byte valid |
| rx_slot | output | 5 | Slot of the received byte |
| rx_byte | output | 8 | Received byte, format removed |
| tone_dur | output | 1 | Tone duration for this frame |
| tone_frq | output | 1 | Tone frequency level for this frame |

## Verification
The checker keeps its own frame position and pulse count from `fp_n`. This relies on the frame pulse being low for exactly one sampled cycle, and on `xbit` changing only away from frame starts. The stimulus meets both conditions. Pulses are one clock wide. Mode changes are made ten cycles into an unchecked frame, and the following frame pulse realigns everything before checking resumes. Inputs are driven one time unit after a rising edge and outputs are read while the clock is high.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int BYTE_W = 8;

  // inversion mask per format code; the sign bit is never touched
  function automatic logic [BYTE_W-1:0] fmt_mask(input logic [1:0] code);
    logic [BYTE_W-1:0] m;
    case (code)
      2'd1:    m = 8'h55;
      2'd2:    m = 8'h2A;
      2'd3:    m = 8'h7F;
      default: m = 8'h00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int SLOTS = 32,
  parameter int CW    = 11,
  parameter int SW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  input  logic          xbit,
  input  logic          td,
  input  logic          tf,
  output logic          cur_vld,
  output logic          cur_first,
  output logic [SW-1:0] cur_slot,
  output logic [2:0]    cur_bit,
  output logic          nxt_vld,
  output logic          nxt_first,
  output logic [2:0]    nxt_bit,
  output logic          ready_nx,
  output logic          hold,
  output logic          tone_dur,
  output logic          tone_frq
);

  localparam int NBITS = SLOTS * pcm_port_pkg::BYTE_W;
  localparam logic [CW-2:0] NB_C = (CW-1)'(NBITS);

  logic [CW-1:0] cyc, cyc_nx;
  logic          sync, sync_nx;
  logic          fp_q;
  logic [1:0]    fcnt, fcnt_nx;
  logic          tdur_nx, tfrq_nx;
  logic          fs;
  logic [CW-2:0] cell_c, chb_c, cell_n, chb_n;

  assign fs = fp_q & ~fp_n;

  // next-state
  always_comb begin
    sync_nx = sync | fs;
    if (fs)
      cyc_nx = '0;
    else if (sync && (cyc != '1))
      cyc_nx = cyc + 1'b1;
    else
      cyc_nx = cyc;
    fcnt_nx = (fs && (fcnt != 2'd3)) ? fcnt + 2'd1 : fcnt;
    tdur_nx = fs ? td : tone_dur;
    tfrq_nx = fs ? tf : tone_frq;
  end

  // cell decode for the present and the following cycle
  always_comb begin
    cell_c    = cyc[CW-1:1];
    chb_c     = xbit ? cell_c - 1'b1 : cell_c;
    cur_vld   = sync && !(xbit && (cell_c == '0)) && (chb_c < NB_C);
    cur_first = ~cyc[0];
    cur_slot  = chb_c[SW+2:3];
    cur_bit   = chb_c[2:0];

    cell_n    = cyc_nx[CW-1:1];
    chb_n     = xbit ? cell_n - 1'b1 : cell_n;
    nxt_vld   = sync_nx && !(xbit && (cell_n == '0)) && (chb_n < NB_C);
    nxt_first = ~cyc_nx[0];
    nxt_bit   = chb_n[2:0];

    ready_nx  = (fcnt_nx == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc      <= '0;
      sync     <= 1'b0;
      fp_q     <= 1'b1;
      fcnt     <= 2'd0;
      tone_dur <= 1'b0;
      tone_frq <= 1'b0;
    end else begin
      cyc      <= cyc_nx;
      sync     <= sync_nx;
      fp_q     <= fp_n;
      fcnt     <= fcnt_nx;
      tone_dur <= tdur_nx;
      tone_frq <= tfrq_nx;
    end
  end

  // clock hold decided in the low phase, covering the next high phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      hold <= 1'b0;
    else
      hold <= xbit && sync_nx && (cyc_nx < CW'(2));
  end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          cur_vld,
  input  logic          cur_first,
  input  logic [SW-1:0] cur_slot,
  input  logic [2:0]    cur_bit,
  input  logic [7:0]    mask,
  output logic          rx_stb,
  output logic [SW-1:0] rx_slot,
  output logic [7:0]    rx_byte
);

  logic [7:0]    sr, sr_nx, shifted, byte_nx;
  logic [SW-1:0] slot_nx;
  logic          sample, last;

  always_comb begin
    sample  = cur_vld & cur_first;
    shifted = {sr[6:0], din};
    last    = sample && (cur_bit == 3'd7);
    sr_nx   = sample ? shifted : sr;
    byte_nx = last ? (shifted ^ mask) : rx_byte;
    slot_nx = last ? cur_slot : rx_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      rx_stb  <= 1'b0;
      rx_slot <= '0;
      rx_byte <= '0;
    end else begin
      sr      <= sr_nx;
      rx_stb  <= last;
      rx_slot <= slot_nx;
      rx_byte <= byte_nx;
    end
  end

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nxt_vld,
  input  logic       nxt_first,
  input  logic [2:0] nxt_bit,
  input  logic       ready_nx,
  input  logic [7:0] tx_byte,
  input  logic       tx_sel,
  input  logic [7:0] mask,
  output logic       dout,
  output logic       dout_oe
);

  logic [7:0] sr, sr_nx, enc;
  logic       act, act_nx, do_nx, oe_nx;
  logic       step, load;

  always_comb begin
    step   = nxt_vld & nxt_first;
    load   = step && (nxt_bit == 3'd0);
    enc    = tx_byte ^ mask;
    sr_nx  = sr;
    do_nx  = dout;
    act_nx = act;
    if (load) begin
      sr_nx  = {enc[6:0], 1'b0};
      do_nx  = enc[7];
      act_nx = tx_sel;
    end else if (step) begin
      sr_nx  = {sr[6:0], 1'b0};
      do_nx  = sr[7];
    end
    if (!nxt_vld)
      oe_nx = 1'b0;
    else if (step)
      oe_nx = act_nx & ready_nx;
    else
      oe_nx = dout_oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      act     <= 1'b0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      sr      <= sr_nx;
      act     <= act_nx;
      dout    <= do_nx;
      dout_oe <= oe_nx;
    end
  end

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int SLOTS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fp_n,
  input  logic       din,
  input  logic       xbit,
  input  logic [1:0] fmt,
  input  logic       td,
  input  logic       tf,
  input  logic [7:0] tx_byte,
  input  logic       tx_sel,
  output logic       dout,
  output logic       dout_oe,
  output logic       clk_out,
  output logic       rx_stb,
  output logic [4:0] rx_slot,
  output logic [7:0] rx_byte,
  output logic       tone_dur,
  output logic       tone_frq
);

  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(2 * (SLOTS * pcm_port_pkg::BYTE_W + 1)) + 1;

  logic [1:0]    rs;
  logic          rst_s;
  logic          cur_vld, cur_first, nxt_vld, nxt_first, ready_nx, hold;
  logic [SW-1:0] cur_slot;
  logic [2:0]    cur_bit, nxt_bit;
  logic [7:0]    mask;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign rst_s = rs[1];

  assign mask    = pcm_port_pkg::fmt_mask(fmt);
  assign clk_out = clk & ~hold;

  pcm_frame_timer #(.SLOTS(SLOTS), .CW(CW), .SW(SW)) u_tmr (
    .clk(clk), .rst_n(rst_s), .fp_n(fp_n), .xbit(xbit), .td(td), .tf(tf),
    .cur_vld(cur_vld), .cur_first(cur_first), .cur_slot(cur_slot), .cur_bit(cur_bit),
    .nxt_vld(nxt_vld), .nxt_first(nxt_first), .nxt_bit(nxt_bit),
    .ready_nx(ready_nx), .hold(hold), .tone_dur(tone_dur), .tone_frq(tone_frq)
  );

  pcm_rx_deser #(.SW(SW)) u_rx (
    .clk(clk), .rst_n(rst_s), .din(din), .cur_vld(cur_vld), .cur_first(cur_first),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .mask(mask),
    .rx_stb(rx_stb), .rx_slot(rx_slot), .rx_byte(rx_byte)
  );

  pcm_tx_ser u_tx (
    .clk(clk), .rst_n(rst_s), .nxt_vld(nxt_vld), .nxt_first(nxt_first),
    .nxt_bit(nxt_bit), .ready_nx(ready_nx), .tx_byte(tx_byte), .tx_sel(tx_sel),
    .mask(mask), .dout(dout), .dout_oe(dout_oe)
  );

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic fp_n,
  input logic xbit,
  input logic dout_oe,
  input logic rx_stb,
  input logic tone_dur,
  input logic tone_frq
);

  logic        fpq, seen;
  logic [10:0] pos;
  logic [1:0]  npul;

  // independent frame position and pulse count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpq  <= 1'b1;
      seen <= 1'b0;
      pos  <= '0;
      npul <= 2'd0;
    end else begin
      fpq <= fp_n;
      if (fpq && !fp_n) begin
        pos  <= '0;
        seen <= 1'b1;
        if (npul != 2'd3) npul <= npul + 2'd1;
      end else if (pos != '1) begin
        pos <= pos + 11'd1;
      end
    end
  end

  p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> !rx_stb);

  p_stb_second_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |-> (seen && pos[0]));

  p_oe_framing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xbit && seen && (pos < 11'd2)) |-> !dout_oe);

  p_oe_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (npul != 2'd3) |-> !dout_oe);

  p_tone_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fpq && !fp_n) |=> $stable({tone_dur, tone_frq}));

endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .xbit(xbit), .dout_oe(dout_oe),
  .rx_stb(rx_stb), .tone_dur(tone_dur), .tone_frq(tone_frq)
);

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;

  localparam int CLK_P = 10;

  logic       clk, rst_n, fp_n, din, xbit, td, tf, tx_sel;
  logic [1:0] fmt;
  logic [7:0] tx_byte;
  logic       dout, dout_oe, clk_out, rx_stb, tone_dur, tone_frq;
  logic [4:0] rx_slot;
  logic [7:0] rx_byte;

  int total = 0;
  int bad   = 0;
  int nfs   = 0;
  bit exp_td = 0, exp_tf = 0;

  pcm_serial_port uut (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .din(din), .xbit(xbit), .fmt(fmt),
    .td(td), .tf(tf), .tx_byte(tx_byte), .tx_sel(tx_sel), .dout(dout),
    .dout_oe(dout_oe), .clk_out(clk_out), .rx_stb(rx_stb), .rx_slot(rx_slot),
    .rx_byte(rx_byte), .tone_dur(tone_dur), .tone_frq(tone_frq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic logic [7:0] fm(input logic [1:0] f);
    case (f)
      2'd1: return 8'h55;
      2'd2: return 8'h2A;
      2'd3: return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] tx_pat(input int s);
    return 8'((s * 71 + 13) & 255);
  endfunction

  function automatic bit sel_of(input int s);
    return (s % 3) != 1;
  endfunction

  function automatic logic [7:0] rx_pat(input int s, input int seed);
    return 8'((s * 53 + seed * 11 + 3) & 255);
  endfunction

  // channel bit index of the cell in cycle c, or -1
  function automatic int cell_of(input int c, input bit xb);
    int cl;
    cl = c / 2;
    if (xb) begin
      if (cl == 0) return -1;
      cl = cl - 1;
    end
    if (cl >= 256) return -1;
    return cl;
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fp_n = 1'b1; din = 1'b0; xbit = 1'b0; fmt = 2'd0;
    td = 1'b0; tf = 1'b0; tx_byte = 8'h00; tx_sel = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    check("R10 oe", dout_oe, 0);
    check("R10 stb", rx_stb, 0);
    check("R10 clk_out high", clk_out, 1);
    #4;
    check("R10 clk_out low", clk_out, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1 din = i[0];
      #2;
      check("R1 idle stb", rx_stb, 0);
      check("R1 idle oe", dout_oe, 0);
      check("R10 idle clk_out", clk_out, 1);
    end
  endtask

  task automatic t_sync();
    @(posedge clk); #1;
    fp_n = 1'b0; tx_byte = tx_pat(0); tx_sel = sel_of(0);
    @(posedge clk);
    nfs = 1; exp_td = td; exp_tf = tf;
  endtask

  // one frame; the cycle-0 edge has just happened on entry
  task automatic run_frame(input int len, input bit xb, input logic [1:0] f,
                           input bit chk, input int seed, input bit ntd, input bit ntf);
    int ch, s, b, nc;
    logic [7:0] e, l;
    bit oe_e, stb_e;
    for (int c = 0; c < len; c++) begin
      #1;
      fp_n = (c == len - 1) ? 1'b0 : 1'b1;
      if (!chk && c == 10) begin xbit = xb; fmt = f; end
      ch = cell_of(c, xbit);
      if (ch >= 0) begin l = rx_pat(ch / 8, seed); din = l[7 - ch % 8]; end
      else din = 1'b1;
      if (c == len - 1) begin
        tx_byte = tx_pat(0); tx_sel = sel_of(0);
      end else begin
        nc = cell_of(c + 1, xbit);
        if (nc >= 0 && ((c + 1) % 2 == 0) && (nc % 8 == 0)) begin
          tx_byte = tx_pat(nc / 8); tx_sel = sel_of(nc / 8);
        end
      end
      if (c < len / 2) begin td = ~ntd; tf = ~ntf; end
      else begin td = ntd; tf = ntf; end
      #2;
      if (chk) begin
        s = ch / 8; b = ch % 8;
        oe_e = (ch >= 0) && (nfs >= 3) && sel_of(s);
        if (nfs < 3) check("R9 oe during init", dout_oe, 0);
        else if (xb && ch < 0) check("R6 oe framing", dout_oe, 0);
        else check("R4 oe", dout_oe, oe_e);
        if (oe_e && dout_oe) begin
          e = tx_pat(s) ^ fm(f);
          check(f == 2'd0 ? "R3 dout" : "R5 dout", dout, e[7 - b]);
        end
        stb_e = (ch >= 0) && (b == 7) && (c % 2 == 1);
        check(xb ? "R6 stb" : "R2 stb", rx_stb, stb_e);
        if (stb_e && rx_stb) begin
          check("R1 slot", rx_slot, s);
          check(f == 2'd0 ? "R2 byte" : "R5 byte", rx_byte, rx_pat(s, seed) ^ fm(f));
        end
        check("R7 clk_out", clk_out, !(xb && c < 2));
        check("R8 tone_dur", tone_dur, exp_td);
        check("R8 tone_frq", tone_frq, exp_tf);
      end
      @(posedge clk);
    end
    nfs++; exp_td = ntd; exp_tf = ntf;
  endtask

  task automatic t_init_frames();
    run_frame(512, 1'b0, 2'd0, 1'b1, 1, 1'b1, 1'b0);
    run_frame(512, 1'b0, 2'd0, 1'b1, 2, 1'b0, 1'b1);
  endtask

  task automatic t_plain_format();
    run_frame(512, 1'b0, 2'd0, 1'b1, 3, 1'b1, 1'b1);
  endtask

  task automatic t_formats();
    for (int f = 1; f < 4; f++) begin
      run_frame(512, 1'b0, 2'(f), 1'b0, 9, 1'b0, 1'b0);
      run_frame(512, 1'b0, 2'(f), 1'b1, 4 + f, f[0], f[1]);
    end
  endtask

  task automatic t_extra_bit();
    run_frame(512, 1'b1, 2'd1, 1'b0, 9, 1'b1, 1'b0);
    run_frame(386, 1'b1, 2'd1, 1'b1, 11, 1'b0, 1'b1);
    run_frame(386, 1'b1, 2'd1, 1'b1, 12, 1'b1, 1'b1);
  endtask

  task automatic t_back_to_normal();
    run_frame(386, 1'b0, 2'd2, 1'b0, 9, 1'b0, 1'b0);
    run_frame(512, 1'b0, 2'd2, 1'b1, 13, 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sync();
    t_init_frames();
    t_plain_format();
    t_formats();
    t_extra_bit();
    t_back_to_normal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule